// File: doc/BRIEF.md
# Flash command decoder

This block sits between a host bus and the internal machinery of a parallel flash device. Each bus write carries an 8-bit command code in the low byte of its data word. The block decodes these codes and keeps track of two-write sequences: a setup code followed by a confirm or data write. It issues single-cycle requests to the program/erase sequencer and to the block lock controller. It also selects which source answers a read: the array, the status byte, the identifier/configuration space, or the query table.

The block models the bus as synchronous strobes sampled on `clk`. It has no pin timing and no tri-state logic. The state of the running operation lives in the decoder: ready, busy, erase suspended, program suspended, or a program running inside an erase suspend. From that state it builds the status byte and decides which codes are accepted. The sequencer reports the end of an operation with `seq_done` and the outcome with `seq_fail`.

The configuration source data is produced here. The array and query data come from outside, steered by `rd_src`; for those two sources `rd_data` is zero.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `rd_src` is 0 (array) and `status` is 80h. No request output is high in the same cycle as another.
- R2: A legal write of FFh, 70h, 90h or 98h sets `rd_src` to 0, 1, 2 or 3 respectively from the next cycle. 50h, accepted only when no operation is running or suspended, clears status bits 5, 4 and 1.
- R3: A write of 40h or 10h arms a program. The next write pulses `op_start` with `op_kind`=0 and carries its address and whole data word. It also makes status bit 7 (ready) 0 and sets `rd_src` to 1.
- R4: After 20h, a write of D0h starts an erase (`op_kind`=1) at its address. Any other code sets status bits 5 and 4, sets `rd_src` to 1 and starts nothing.
- R5: After 60h, a write of 01h, D0h or 2Fh pulses `lk_req` with `lk_op` 1 (lock), 2 (unlock) or 3 (lock-down) and the write address. Any other code sets bits 5 and 4 and sets `rd_src` to 1.
- R6: While an operation runs, only 70h and B0h take effect. B0h pulses `susp_req` and sets bit 7. It also sets bit 6 if the running operation is an erase, or bit 2 if it is a program.
- R7: D0h with no setup pending does the following when an operation is suspended: it pulses `resume_req`, clears bit 7 and the suspend bit, and sets `rd_src` to 1. In any other state it has no effect.
- R8: In erase suspend, only these codes are accepted: FFh, 70h, 90h, 98h, 40h/10h, D0h and 60h (with its lock confirms). A program started there keeps bit 6 set. When that program completes, the block returns to erase suspend. In program suspend, only FFh, 70h, 90h, 98h and D0h are accepted.
- R9: `seq_done` ends the running operation. If `seq_fail` is also high, it sets bit 5 for an erase, or bit 4 for a program or protection write. These bits stay set until 50h.
- R10: With `rd_src`=2, `rd_data` depends on `rd_addr` as follows. Address 0 returns 0089h and address 1 returns the device ID. A block offset (low 15 address bits) of 2 returns `blk_lock_st` in bits 1:0. All other addresses return 0.
- R11: With `rd_src`=1, `rd_data` is 00h in the upper byte and the status byte in the lower byte. For sources 0 and 3 it is 0.
- R12: A write of C0h arms a protection register write. The next write selects word `wr_addr[2:0]`. If `otp_lock` has that bit set, the write is refused: bits 4 and 1 are set and `rd_src` becomes 1. Otherwise it starts with `op_kind`=2.
- R13: If B0h arrives in the same cycle as `seq_done`, the operation completes and no suspend is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data; command code in bits 7:0 |
| rd_addr | input | ADDR_W | Read address |
| blk_lock_st | input | 2 | Lock state of the block at `rd_addr` |
| otp_lock | input | OTP_WORDS | Per-word lock bits of the protection register |
| seq_done | input | 1 | Sequencer finished the running operation |
| seq_fail | input | 1 | Outcome of that operation was a failure |
| rd_src | output | 2 | Read source: 0 array, 1 status, 2 config, 3 query |
| rd_data | output | 16 | Status or configuration read data |
| status | output | 8 | Status byte |
| op_start | output | 1 | Start pulse to the sequencer |
| op_kind | output | 2 | 0 program, 1 erase, 2 protection write |
| op_addr | output | ADDR_W | Operation address |
| op_data | output | 16 | Program data |
| susp_req | output | 1 | Suspend pulse |
| resume_req | output | 1 | Resume pulse |
| lk_req | output | 1 | Lock-change pulse |
| lk_op | output | 2 | 1 lock, 2 unlock, 3 lock-down |
| lk_addr | output | ADDR_W | Block address for the lock change |

## Verification
The hardest state to reach is a program running inside a suspended erase. The stimulus gets there in five steps: start an erase, suspend it, arm and issue a program, probe the filter with illegal codes, and end the nested program with `seq_done`. The same path then issues a lock change before resuming. A separate case puts B0h and `seq_done` on the same cycle. A behavioural model in the bench predicts every output on every cycle, so a code that leaks through the filter shows up as a mismatch.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int          ADDR_W    = 21,
  parameter int          BLK_OFS_W = 15,
  parameter int          OTP_WORDS = 8,
  parameter logic [15:0] MFR_ID    = 16'h0089,
  parameter logic [15:0] DEV_ID    = 16'h88C2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        blk_lock_st,
  input  logic [OTP_WORDS-1:0] otp_lock,
  input  logic              seq_done,
  input  logic              seq_fail,
  output logic [1:0]        rd_src,
  output logic [15:0]       rd_data,
  output logic [7:0]        status,
  output logic              op_start,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [15:0]       op_data,
  output logic              susp_req,
  output logic              resume_req,
  output logic              lk_req,
  output logic [1:0]        lk_op,
  output logic [ADDR_W-1:0] lk_addr
);
  localparam int OTP_IDX_W = (OTP_WORDS > 1) ? $clog2(OTP_WORDS) : 1;

  localparam logic [1:0] M_ARR = 2'd0, M_STAT = 2'd1, M_CFG = 2'd2, M_QRY = 2'd3;
  localparam logic [1:0] K_PROG = 2'd0, K_ERASE = 2'd1, K_OTP = 2'd2;

  typedef enum logic [2:0] {S_RDY, S_BUSY, S_SUSE, S_SUSP, S_ESPB} st_t;
  typedef enum logic [2:0] {P_NONE, P_PROG, P_ERASE, P_CFG, P_OTP} pend_t;

  st_t        st;
  pend_t      pend;
  logic [1:0] mode;
  logic       run_erase;
  logic       e5, e4, e1;
  logic       legal;
  logic [15:0] cfg_word;

  wire [7:0] cmd    = wr_data[7:0];
  wire       busy   = (st == S_BUSY) || (st == S_ESPB);
  wire       second = wr_en && (pend != P_NONE);
  wire       fresh  = wr_en && (pend == P_NONE) && legal;
  wire [OTP_IDX_W-1:0] otp_idx = wr_addr[OTP_IDX_W-1:0];

  always_comb begin
    case (st)
      S_RDY:   legal = 1'b1;
      S_BUSY:  legal = (cmd == 8'h70) || (cmd == 8'hB0);
      S_ESPB:  legal = (cmd == 8'h70);
      S_SUSE:  legal = (cmd == 8'hFF) || (cmd == 8'h70) || (cmd == 8'h90) ||
                       (cmd == 8'h98) || (cmd == 8'h40) || (cmd == 8'h10) ||
                       (cmd == 8'hD0) || (cmd == 8'h60);
      S_SUSP:  legal = (cmd == 8'hFF) || (cmd == 8'h70) || (cmd == 8'h90) ||
                       (cmd == 8'h98) || (cmd == 8'hD0);
      default: legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RDY;
      pend       <= P_NONE;
      mode       <= M_ARR;
      run_erase  <= 1'b0;
      e5         <= 1'b0;
      e4         <= 1'b0;
      e1         <= 1'b0;
      op_start   <= 1'b0;
      op_kind    <= K_PROG;
      op_addr    <= '0;
      op_data    <= '0;
      susp_req   <= 1'b0;
      resume_req <= 1'b0;
      lk_req     <= 1'b0;
      lk_op      <= 2'd0;
      lk_addr    <= '0;
    end else begin
      op_start   <= 1'b0;
      susp_req   <= 1'b0;
      resume_req <= 1'b0;
      lk_req     <= 1'b0;

      if (second) begin
        pend <= P_NONE;
        case (pend)
          P_PROG: begin
            op_start <= 1'b1;
            op_kind  <= K_PROG;
            op_addr  <= wr_addr;
            op_data  <= wr_data;
            mode     <= M_STAT;
            if (st == S_SUSE) st <= S_ESPB;
            else begin
              st        <= S_BUSY;
              run_erase <= 1'b0;
            end
          end
          P_ERASE: begin
            mode <= M_STAT;
            if (cmd == 8'hD0) begin
              op_start  <= 1'b1;
              op_kind   <= K_ERASE;
              op_addr   <= wr_addr;
              st        <= S_BUSY;
              run_erase <= 1'b1;
            end else begin
              e5 <= 1'b1;
              e4 <= 1'b1;
            end
          end
          P_CFG: begin
            if (cmd == 8'h01 || cmd == 8'hD0 || cmd == 8'h2F) begin
              lk_req  <= 1'b1;
              lk_addr <= wr_addr;
              lk_op   <= (cmd == 8'h01) ? 2'd1 : (cmd == 8'hD0) ? 2'd2 : 2'd3;
            end else begin
              e5   <= 1'b1;
              e4   <= 1'b1;
              mode <= M_STAT;
            end
          end
          P_OTP: begin
            mode <= M_STAT;
            if (otp_lock[otp_idx]) begin
              e4 <= 1'b1;
              e1 <= 1'b1;
            end else begin
              op_start  <= 1'b1;
              op_kind   <= K_OTP;
              op_addr   <= wr_addr;
              op_data   <= wr_data;
              st        <= S_BUSY;
              run_erase <= 1'b0;
            end
          end
          default: ;
        endcase
      end else if (fresh) begin
        case (cmd)
          8'hFF: mode <= M_ARR;
          8'h70: mode <= M_STAT;
          8'h90: mode <= M_CFG;
          8'h98: mode <= M_QRY;
          8'h50: begin
            e5 <= 1'b0;
            e4 <= 1'b0;
            e1 <= 1'b0;
          end
          8'h40, 8'h10: pend <= P_PROG;
          8'h20: pend <= P_ERASE;
          8'h60: pend <= P_CFG;
          8'hC0: pend <= P_OTP;
          8'hB0: if (st == S_BUSY && !seq_done) begin
            susp_req <= 1'b1;
            st       <= run_erase ? S_SUSE : S_SUSP;
          end
          8'hD0: if (st == S_SUSE || st == S_SUSP) begin
            resume_req <= 1'b1;
            mode       <= M_STAT;
            st         <= S_BUSY;
            run_erase  <= (st == S_SUSE);
          end
          default: ;
        endcase
      end

      if (seq_done && busy) begin
        st <= (st == S_ESPB) ? S_SUSE : S_RDY;
        if (seq_fail) begin
          if (st == S_BUSY && run_erase) e5 <= 1'b1;
          else e4 <= 1'b1;
        end
      end
    end
  end

  assign status = {~busy, (st == S_SUSE) || (st == S_ESPB), e5, e4,
                   1'b0, (st == S_SUSP), e1, 1'b0};

  always_comb begin
    if (rd_addr == '0)                                 cfg_word = MFR_ID;
    else if (rd_addr == ADDR_W'(1))                    cfg_word = DEV_ID;
    else if (rd_addr[BLK_OFS_W-1:0] == BLK_OFS_W'(2))  cfg_word = {14'd0, blk_lock_st};
    else                                               cfg_word = 16'd0;
  end

  assign rd_src  = mode;
  assign rd_data = (mode == M_STAT) ? {8'h00, status} :
                   (mode == M_CFG)  ? cfg_word : 16'd0;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [7:0]  status,
  input logic        op_start,
  input logic [1:0]  op_kind,
  input logic        susp_req,
  input logic        resume_req,
  input logic        lk_req
);
  a_r1_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_start, susp_req, resume_req, lk_req}));

  a_r3_start_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !status[7] && op_kind != 2'd3);

  a_r6_suspend_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> status[7] && (status[6] || status[2]) && !$past(status[7]));

  a_r7_resume_from_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> !status[7] && $past(status[7]) && ($past(status[6]) || $past(status[2])));

  a_r8_one_suspend_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[6] && status[2]));

  a_r9_errors_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(status[4]) || $fell(status[5])) |-> $past(wr_en && wr_data[7:0] == 8'h50));

  a_r8_start_from_idle_or_esusp: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(status[7]) && !$past(status[2]));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .status(status),
  .op_start(op_start), .op_kind(op_kind), .susp_req(susp_req),
  .resume_req(resume_req), .lk_req(lk_req)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [20:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [20:0] rd_addr = '0;
  logic [1:0]  blk_lock_st = '0;
  logic [7:0]  otp_lock = '0;
  logic        seq_done = 1'b0;
  logic        seq_fail = 1'b0;
  logic [1:0]  rd_src;
  logic [15:0] rd_data;
  logic [7:0]  status;
  logic        op_start, susp_req, resume_req, lk_req;
  logic [1:0]  op_kind, lk_op;
  logic [20:0] op_addr, lk_addr;
  logic [15:0] op_data;

  always #4 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .blk_lock_st(blk_lock_st), .otp_lock(otp_lock),
    .seq_done(seq_done), .seq_fail(seq_fail), .rd_src(rd_src), .rd_data(rd_data),
    .status(status), .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .susp_req(susp_req), .resume_req(resume_req),
    .lk_req(lk_req), .lk_op(lk_op), .lk_addr(lk_addr)
  );

  int    vectors = 0, miscompares = 0;
  bit    live = 0, finished = 0;
  string cur_req = "R1";

  int m_mode, m_st, m_pend;
  bit m_rerase, m_e5, m_e4, m_e1;
  bit x_start, x_susp, x_res, x_lk;
  int x_kind, x_lkop;
  logic [20:0] x_addr, x_lkaddr;
  logic [15:0] x_data;

  function automatic int m_status();
    int s = 0;
    if (!(m_st == 1 || m_st == 4)) s += 128;
    if (m_st == 2 || m_st == 4) s += 64;
    if (m_e5) s += 32;
    if (m_e4) s += 16;
    if (m_st == 3) s += 4;
    if (m_e1) s += 2;
    return s;
  endfunction

  function automatic bit m_accepts(int c);
    case (m_st)
      0: return 1;
      1: return c == 'h70 || c == 'hB0;
      4: return c == 'h70;
      2: return c inside {'hFF, 'h70, 'h90, 'h98, 'h40, 'h10, 'hD0, 'h60};
      3: return c inside {'hFF, 'h70, 'h90, 'h98, 'hD0};
      default: return 0;
    endcase
  endfunction

  function automatic int m_rd();
    if (m_mode == 1) return m_status();
    if (m_mode == 2) begin
      if (rd_addr == 0) return 'h0089;
      if (rd_addr == 1) return 'h88C2;
      if ((rd_addr % 32768) == 2) return int'(blk_lock_st);
      return 0;
    end
    return 0;
  endfunction

  task automatic model_reset();
    m_mode = 0; m_st = 0; m_pend = 0; m_rerase = 0;
    m_e5 = 0; m_e4 = 0; m_e1 = 0;
    x_start = 0; x_susp = 0; x_res = 0; x_lk = 0;
  endtask

  task automatic model_step();
    int c = int'(wr_data[7:0]);
    x_start = 0; x_susp = 0; x_res = 0; x_lk = 0;
    if (wr_en && m_pend != 0) begin
      int p = m_pend;
      m_pend = 0;
      if (p == 1) begin
        x_start = 1; x_kind = 0; x_addr = wr_addr; x_data = wr_data; m_mode = 1;
        if (m_st == 2) m_st = 4; else begin m_st = 1; m_rerase = 0; end
      end else if (p == 2) begin
        m_mode = 1;
        if (c == 'hD0) begin x_start = 1; x_kind = 1; x_addr = wr_addr; m_st = 1; m_rerase = 1; end
        else begin m_e5 = 1; m_e4 = 1; end
      end else if (p == 3) begin
        if (c == 'h01) begin x_lk = 1; x_lkop = 1; x_lkaddr = wr_addr; end
        else if (c == 'hD0) begin x_lk = 1; x_lkop = 2; x_lkaddr = wr_addr; end
        else if (c == 'h2F) begin x_lk = 1; x_lkop = 3; x_lkaddr = wr_addr; end
        else begin m_e5 = 1; m_e4 = 1; m_mode = 1; end
      end else begin
        m_mode = 1;
        if (otp_lock[wr_addr % 8]) begin m_e4 = 1; m_e1 = 1; end
        else begin x_start = 1; x_kind = 2; x_addr = wr_addr; x_data = wr_data; m_st = 1; m_rerase = 0; end
      end
    end else if (wr_en && m_accepts(c)) begin
      if (c == 'hFF) m_mode = 0;
      else if (c == 'h70) m_mode = 1;
      else if (c == 'h90) m_mode = 2;
      else if (c == 'h98) m_mode = 3;
      else if (c == 'h50) begin m_e5 = 0; m_e4 = 0; m_e1 = 0; end
      else if (c == 'h40 || c == 'h10) m_pend = 1;
      else if (c == 'h20) m_pend = 2;
      else if (c == 'h60) m_pend = 3;
      else if (c == 'hC0) m_pend = 4;
      else if (c == 'hB0 && m_st == 1 && !seq_done) begin
        x_susp = 1; m_st = m_rerase ? 2 : 3;
      end else if (c == 'hD0 && (m_st == 2 || m_st == 3)) begin
        x_res = 1; m_mode = 1; m_rerase = (m_st == 2); m_st = 1;
      end
    end
    if (seq_done && (m_st == 1 || m_st == 4)) begin
      if (seq_fail) begin
        if (m_st == 1 && m_rerase) m_e5 = 1; else m_e4 = 1;
      end
      m_st = (m_st == 4) ? 2 : 0;
    end
  endtask

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp("rd_src", int'(rd_src), m_mode);
    cmp("rd_data", int'(rd_data), m_rd());
    cmp("status", int'(status), m_status());
    cmp("op_start", int'(op_start), int'(x_start));
    cmp("susp_req", int'(susp_req), int'(x_susp));
    cmp("resume_req", int'(resume_req), int'(x_res));
    cmp("lk_req", int'(lk_req), int'(x_lk));
    if (x_start) begin
      cmp("op_kind", int'(op_kind), x_kind);
      cmp("op_addr", int'(op_addr), int'(x_addr));
      if (x_kind != 1) cmp("op_data", int'(op_data), int'(x_data));
    end
    if (x_lk) begin
      cmp("lk_op", int'(lk_op), x_lkop);
      cmp("lk_addr", int'(lk_addr), int'(x_lkaddr));
    end
  endtask

  task automatic step(bit w, logic [20:0] a, logic [15:0] d, bit dn = 0, bit fl = 0);
    @(negedge clk);
    if (live) compare_all();
    wr_en = w; wr_addr = a; wr_data = d; seq_done = dn; seq_fail = fl;
    model_step();
  endtask

  task automatic wr(logic [20:0] a, logic [15:0] d);
    step(1, a, d);
  endtask

  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) step(0, '0, '0);
  endtask

  task automatic done(bit fl = 0);
    step(0, '0, '0, 1, fl);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    live = 1;
    cur_req = "R1"; idle(2);

    cur_req = "R10"; wr(0, 16'h0090); idle();
    rd_addr = 21'd1; idle();
    rd_addr = 21'h18002; blk_lock_st = 2'd3; idle();
    rd_addr = 21'h00005; idle();
    rd_addr = 21'h00000; idle();
    cur_req = "R2"; wr(0, 16'h0098); idle();
    cur_req = "R11"; wr(0, 16'h0070); idle();
    cur_req = "R2"; wr(0, 16'h00FF); idle();

    cur_req = "R3"; wr(0, 16'h0040); wr(21'h01234, 16'hBEEF); idle();
    cur_req = "R6"; wr(0, 16'h0090); wr(0, 16'h0020); wr(0, 16'h00FF); idle();
    wr(0, 16'h0070); idle();
    cur_req = "R9"; done(1); idle();
    cur_req = "R3"; wr(0, 16'h0010); wr(21'h1FFFF, 16'h0001); done(); idle();
    cur_req = "R7"; wr(0, 16'h00D0); idle();

    cur_req = "R4"; wr(0, 16'h0020); wr(21'h08000, 16'h00D0); idle();
    cur_req = "R9"; done(1); idle();
    cur_req = "R2"; wr(0, 16'h0050); idle();
    cur_req = "R4"; wr(0, 16'h0020); wr(0, 16'h00FF); idle();
    wr(0, 16'h0050);

    cur_req = "R5"; wr(0, 16'h0060); wr(21'h10000, 16'h0001);
    wr(0, 16'h0060); wr(21'h10002, 16'h00D0);
    wr(0, 16'h0060); wr(21'h10004, 16'h002F);
    wr(0, 16'h00FF);
    wr(0, 16'h0060); wr(21'h10004, 16'h0055); idle();

    cur_req = "R8"; wr(0, 16'h0020); wr(21'h20000, 16'h00D0);
    cur_req = "R6"; wr(0, 16'h00B0); idle();
    cur_req = "R8"; wr(0, 16'h0090); rd_addr = 21'h20002; blk_lock_st = 2'd1; idle();
    wr(0, 16'h0050); wr(0, 16'h0020); wr(0, 16'h00C0); wr(0, 16'h00B0); idle();
    wr(0, 16'h0040); wr(21'h30000, 16'h1234); idle();
    wr(0, 16'h00B0); wr(0, 16'h0090); wr(0, 16'h00D0); idle();
    done(); idle();
    cur_req = "R5"; wr(0, 16'h0060); wr(21'h30000, 16'h0001);
    cur_req = "R7"; wr(0, 16'h00D0); idle();
    cur_req = "R9"; done(); wr(0, 16'h0050);

    cur_req = "R6"; wr(0, 16'h0040); wr(21'h00100, 16'hA5A5); wr(0, 16'h00B0); idle();
    cur_req = "R8"; wr(0, 16'h0040); wr(0, 16'h0060); wr(0, 16'h0098); idle();
    wr(0, 16'h0050); wr(0, 16'h0020);
    cur_req = "R7"; wr(0, 16'h00D0); idle(); done(); idle();

    cur_req = "R13"; wr(0, 16'h0020); wr(21'h40000, 16'h00D0);
    step(1, '0, 16'h00B0, 1, 0); idle(2);

    cur_req = "R12"; otp_lock = 8'b0000_0100;
    wr(0, 16'h00C0); wr(21'h00002, 16'hCAFE); idle();
    wr(0, 16'h0050);
    wr(0, 16'h00C0); wr(21'h00003, 16'h5A5A); idle(); done(); idle();
    cur_req = "R9"; wr(0, 16'h00C0); wr(21'h00007, 16'h0F0F); done(1); idle();
    wr(0, 16'h0050); idle();
    cur_req = "R11"; wr(0, 16'h0098); idle();

    @(negedge clk);
    compare_all();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule